// File: doc/BRIEF.md
# Clock Calendar Update Engine

This block keeps the time of day and a 100-year calendar. A one-cycle tick from a 1 Hz source starts an update cycle. The busy status rises first. After a programmable pre-update window the internal time advances by one second. One cycle later the new values are copied into a host-visible user copy, a one-cycle done pulse is given, and the busy status falls.

The host reaches the ten user bytes through a simple write port. The byte addresses are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year. Control inputs select the following:
- binary or BCD counting;
- 12-hour or 24-hour counting;
- automatic daylight-saving jumps;
- an inhibit that freezes the user copy while the internal copy keeps counting.

Top module: `rtc_cal_engine`

## Requirements
- R1: After reset the following read as 0: all ten user bytes, the busy status `updInProg` and the pulse `updDone`.
- R2: A tick taken while idle drives the busy status high from the next cycle. The status stays high for PRE_CYCLES+2 cycles. `updDone` is high for exactly the last of those cycles. The user copy shows the advanced time from the cycle after. A tick that arrives during an update cycle is ignored.
- R3: With `binMode`=0 every field counts in BCD: seconds and minutes 00h–59h, year 00h–99h, with decimal carries (09h becomes 10h).
- R4: With `binMode`=1 every field counts in plain binary: seconds and minutes 00h–3Bh, hours 00h–17h, year 00h–63h.
- R5: With `hour24`=0 the hour byte holds 1 to 12, with bit 7 set for PM. The step from 11:59:59 to 12:00:00 toggles bit 7. The step from 12 goes to 1 with bit 7 unchanged.
- R6: With `hour24`=1 the hour runs from 0 to 23, and 23:59:59 rolls to 00:00:00 and advances the date.
- R7: On a day rollover the day of week goes from 7 to 1 (1 is Sunday) and otherwise up by one. The day of month returns to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. The month goes from 12 to 1, and the year goes from 99 to 0.
- R8: February has 29 days when the year value mod 4 is 0 and 28 days otherwise.
- R9: While `inhibit`=1 the following apply:
  - updates leave the user time bytes unchanged;
  - `updInProg` reads 0;
  - `updDone` still pulses;
  - the internal time keeps advancing, and the next transfer after `inhibit` clears shows the advanced time.
- R10: A host write always reaches the user byte at once. A write to a time byte while `inhibit`=1 is loaded into the internal copy when `inhibit` returns to 0, so the next update continues from the written value.
- R11: With `dstEn`=1, on a Sunday (day of week 1) in month 4 with day of month 1 to 7, the step from 1:59:59 goes to 3:00:00.
- R12: With `dstEn`=1, on a Sunday in month 10 with day of month 25 or more, the step from 1:59:59 goes to 1:00:00, but only once. Later passes on the same day go to 2:00:00 until the next day rollover.
- R13: The alarm bytes (1, 3, 5) hold whatever the host wrote, and updates never alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle 1 Hz update request |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 4 | Host byte address 0–9 (others ignored) |
| wrData | input | 8 | Host write data |
| inhibit | input | 1 | Freeze user copy, 1 = frozen |
| binMode | input | 1 | 1 = binary fields, 0 = BCD |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with bit 7 PM |
| dstEn | input | 1 | 1 = daylight-saving jumps enabled |
| userBytes | output | 80 | User copy, byte i at bits 8i+7:8i |
| updInProg | output | 1 | Update cycle in progress (0 while inhibited) |
| updDone | output | 1 | One-cycle pulse in the last cycle of an update |

## Verification
The bench counts edges from the clock edge that samples the tick:
- busy is due one edge later;
- the done pulse is due PRE_CYCLES+1 edges later;
- the transferred time and the fall of busy are due PRE_CYCLES+2 edges later.

Every check is made at the falling clock edge in exactly those cycles. A host write is visible in the user copy one edge after its strobe is sampled. A second tick sent during the pre-update window is followed by a check that the time advanced only once and that busy stays low for several cycles after the expected end.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_BYTES  = 10;
  localparam int TIME_SLOTS = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_STEP, ST_XFER} calState_t;

  typedef struct packed {
    logic advance;
    logic transfer;
    logic loadDirty;
  } calStrobe_t;

  // Host address of time slot k: 0,2,4 then 6,7,8,9
  function automatic int addrOf(input int k);
    return (k < 3) ? 2 * k : k + 3;
  endfunction

  function automatic logic isTime(input int a);
    return (a < 6) ? (a % 2 == 0) : (a <= 9);
  endfunction

  function automatic int slotOf(input int a);
    return (a < 6) ? a / 2 : a - 3;
  endfunction

  function automatic logic [7:0] toBin(input logic [7:0] v, input logic binMode);
    return binMode ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
  endfunction

  function automatic logic [7:0] toFmt(input logic [7:0] n, input logic binMode);
    return binMode ? n : {4'(n / 8'd10), 4'(n % 8'd10)};
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int PRE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       inhibit,
  output calStrobe_t stb,
  output logic       busyOut,
  output logic       uipOut,
  output logic       doneOut
);

  localparam int CNT_W = $clog2(PRE_CYCLES + 1);

  calState_t  state;
  logic [CNT_W-1:0] waitCnt;
  logic       inhibitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      inhibitQ <= 1'b0;
    end else begin
      inhibitQ <= inhibit;
      case (state)
        ST_IDLE: if (tickIn) begin
          state   <= ST_WAIT;
          waitCnt <= '0;
        end
        ST_WAIT: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt == CNT_W'(PRE_CYCLES - 1)) state <= ST_STEP;
        end
        ST_STEP: state <= ST_XFER;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.advance   = (state == ST_STEP);
    stb.transfer  = (state == ST_XFER) && !inhibit;
    stb.loadDirty = inhibitQ && !inhibit;
  end

  assign busyOut = (state != ST_IDLE);
  assign uipOut  = busyOut && !inhibit;
  assign doneOut = (state == ST_XFER);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R2
  adv_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> doneOut);

  // R2
  tick_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !busyOut) |=> (busyOut && !doneOut));

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  logic [TIME_SLOTS-1:0][7:0] curB,
  input  logic                       binMode,
  input  logic                       hour24,
  input  logic                       dstEn,
  input  logic                       fellBack,
  output logic [TIME_SLOTS-1:0][7:0] nextB,
  output logic                       setFall,
  output logic                       dayRoll
);

  logic [7:0] s, m, h, dw, dm, mo, yr, h12, dim;
  logic [7:0] ns, nm, nh, ndw, ndm, nmo, nyr, h12n, fmtH;
  logic carryS, carryM, monRoll, yrRoll, at159, spring, pm;

  always_comb begin
    s  = toBin(curB[0], binMode);
    m  = toBin(curB[1], binMode);
    dw = toBin(curB[3], binMode);
    dm = toBin(curB[4], binMode);
    mo = toBin(curB[5], binMode);
    yr = toBin(curB[6], binMode);
    h12 = toBin({1'b0, curB[2][6:0]}, binMode);
    if (hour24) h = toBin(curB[2], binMode);
    else begin
      h = (h12 == 8'd12) ? 8'd0 : h12;
      if (curB[2][7]) h = h + 8'd12;
    end

    case (mo)
      8'd2:                      dim = (yr[1:0] == 2'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
      default:                   dim = 8'd31;
    endcase

    carryS  = (s >= 8'd59);
    carryM  = carryS && (m >= 8'd59);
    dayRoll = carryM && (h >= 8'd23);
    ns  = carryS ? 8'd0 : s + 8'd1;
    nm  = carryS ? (carryM ? 8'd0 : m + 8'd1) : m;
    nh  = carryM ? (dayRoll ? 8'd0 : h + 8'd1) : h;
    ndw = dayRoll ? ((dw >= 8'd7) ? 8'd1 : dw + 8'd1) : dw;
    monRoll = dayRoll && (dm >= dim);
    ndm = dayRoll ? (monRoll ? 8'd1 : dm + 8'd1) : dm;
    yrRoll = monRoll && (mo >= 8'd12);
    nmo = monRoll ? (yrRoll ? 8'd1 : mo + 8'd1) : mo;
    nyr = yrRoll ? ((yr >= 8'd99) ? 8'd0 : yr + 8'd1) : yr;

    at159   = (h == 8'd1) && carryM;
    spring  = dstEn && at159 && (mo == 8'd4) && (dw == 8'd1) && (dm <= 8'd7);
    setFall = dstEn && at159 && (mo == 8'd10) && (dw == 8'd1) &&
              (dm >= 8'd25) && !fellBack;
    if (spring)       nh = 8'd3;
    else if (setFall) nh = 8'd1;

    pm   = (nh >= 8'd12);
    h12n = pm ? nh - 8'd12 : nh;
    if (h12n == 8'd0) h12n = 8'd12;
    fmtH = toFmt(h12n, binMode);

    nextB[0] = toFmt(ns, binMode);
    nextB[1] = toFmt(nm, binMode);
    nextB[2] = hour24 ? toFmt(nh, binMode) : {pm, fmtH[6:0]};
    nextB[3] = toFmt(ndw, binMode);
    nextB[4] = toFmt(ndm, binMode);
    nextB[5] = toFmt(nmo, binMode);
    nextB[6] = toFmt(nyr, binMode);
  end

endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  calStrobe_t             stb,
  input  logic                   wrEn,
  input  logic [3:0]             wrAddr,
  input  logic [7:0]             wrData,
  input  logic                   inhibit,
  input  logic                   binMode,
  input  logic                   hour24,
  input  logic                   dstEn,
  output logic [NUM_BYTES*8-1:0] userFlat
);

  logic [TIME_SLOTS-1:0][7:0] intR, nextB;
  logic [TIME_SLOTS-1:0]      dirty;
  logic [NUM_BYTES-1:0][7:0]  userR;
  logic fellBack, setFall, dayRoll;

  rtc_cal_step u_step (
    .curB(intR), .binMode(binMode), .hour24(hour24), .dstEn(dstEn),
    .fellBack(fellBack), .nextB(nextB), .setFall(setFall), .dayRoll(dayRoll)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intR  <= '0;
      dirty <= '0;
    end else begin
      for (int k = 0; k < TIME_SLOTS; k++) begin
        if (wrEn && wrAddr == 4'(addrOf(k))) begin
          if (inhibit) dirty[k] <= 1'b1;
          else         intR[k]  <= wrData;
        end else if (stb.loadDirty && dirty[k]) begin
          intR[k]  <= userR[addrOf(k)];
          dirty[k] <= 1'b0;
        end else if (stb.advance) begin
          intR[k] <= nextB[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fellBack <= 1'b0;
    else if (stb.advance) begin
      if (setFall)      fellBack <= 1'b1;
      else if (dayRoll) fellBack <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) userR <= '0;
    else begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (wrEn && wrAddr == 4'(i))           userR[i] <= wrData;
        else if (stb.transfer && isTime(i))    userR[i] <= intR[slotOf(i)];
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_out
    assign userFlat[8*g +: 8] = userR[g];
  end

  // R9
  user_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !wrEn) |=> $stable(userR));

  // R13
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable({userR[1], userR[3], userR[5]}));

  // R12
  fall_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fellBack && stb.advance && !dayRoll) |=> fellBack);

endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
  import rtc_cal_pkg::*;
#(
  parameter int PRE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        inhibit,
  input  logic        binMode,
  input  logic        hour24,
  input  logic        dstEn,
  output logic [79:0] userBytes,
  output logic        updInProg,
  output logic        updDone
);

  calStrobe_t stb;
  logic busy;

  rtc_cal_ctrl #(.PRE_CYCLES(PRE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .inhibit(inhibit),
    .stb(stb), .busyOut(busy), .uipOut(updInProg), .doneOut(updDone)
  );

  rtc_cal_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .inhibit(inhibit), .binMode(binMode), .hour24(hour24),
    .dstEn(dstEn), .userFlat(userBytes)
  );

  // R2
  busy_covers_uip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updInProg) |-> busy);

endmodule

// File: tb/rtc_cal_engine_tb.sv
module rtc_cal_engine_tb;

  localparam int PRE = 8;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rstN = 1'b0, tickIn = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic inhibit = 1'b0, binMode = 1'b0, hour24 = 1'b1, dstEn = 1'b0;
  logic [79:0] userBytes;
  logic updInProg, updDone;

  int checks = 0, failures = 0;
  bit finished = 0;

  rtc_cal_engine #(.PRE_CYCLES(PRE)) u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .inhibit(inhibit), .binMode(binMode), .hour24(hour24),
    .dstEn(dstEn), .userBytes(userBytes), .updInProg(updInProg), .updDone(updDone)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct packed {
    logic bin, h24, dst;
    logic [7:0] s, m, h, dw, dm, mo, yr;
    logic [7:0] es, em, eh, edw, edm, emo, eyr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R6 R7 year and month wrap, BCD 24h
    '{1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    // R8 leap February
    '{1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24},
    // R8 common February
    '{1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h23},
    // R4 R7 binary, 30-day month
    '{1'b1,1'b1,1'b0, 8'h3B,8'h3B,8'h17,8'h02,8'h1E,8'h04,8'h63, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,8'h63},
    // R5 11 AM to 12 PM
    '{1'b0,1'b0,1'b0, 8'h59,8'h59,8'h11,8'h05,8'h10,8'h06,8'h50, 8'h00,8'h00,8'h92,8'h05,8'h10,8'h06,8'h50},
    // R5 11 PM to 12 AM with day roll
    '{1'b0,1'b0,1'b0, 8'h59,8'h59,8'h91,8'h05,8'h10,8'h06,8'h50, 8'h00,8'h00,8'h12,8'h06,8'h11,8'h06,8'h50},
    // R5 12 PM to 1 PM
    '{1'b0,1'b0,1'b0, 8'h59,8'h59,8'h92,8'h05,8'h10,8'h06,8'h50, 8'h00,8'h00,8'h81,8'h05,8'h10,8'h06,8'h50},
    // R5 R4 binary 12 AM to 1 AM
    '{1'b1,1'b0,1'b0, 8'h3B,8'h3B,8'h0C,8'h05,8'h0A,8'h06,8'h32, 8'h00,8'h00,8'h01,8'h05,8'h0A,8'h06,8'h32},
    // R3 BCD digit carry
    '{1'b0,1'b1,1'b0, 8'h09,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00, 8'h10,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    // R4 binary no digit carry
    '{1'b1,1'b1,1'b0, 8'h09,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00, 8'h0A,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    // R11 disabled: no jump
    '{1'b0,1'b1,1'b0, 8'h59,8'h59,8'h01,8'h01,8'h05,8'h04,8'h26, 8'h00,8'h00,8'h02,8'h01,8'h05,8'h04,8'h26},
    // R11 spring forward
    '{1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h05,8'h04,8'h26, 8'h00,8'h00,8'h03,8'h01,8'h05,8'h04,8'h26},
    // R11 second Sunday: no jump
    '{1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h12,8'h04,8'h26, 8'h00,8'h00,8'h02,8'h01,8'h12,8'h04,8'h26},
    // R12 fall back
    '{1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h27,8'h10,8'h26, 8'h00,8'h00,8'h01,8'h01,8'h27,8'h10,8'h26},
    // R12 only once per day
    '{1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h27,8'h10,8'h26, 8'h00,8'h00,8'h02,8'h01,8'h27,8'h10,8'h26}
  };

  function automatic logic [7:0] ub(input int i);
    return userBytes[8*i +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeTime(input logic [7:0] s, m, h, dw, dm, mo, yr);
    writeByte(0, s); writeByte(2, m); writeByte(4, h);
    writeByte(6, dw); writeByte(7, dm); writeByte(8, mo); writeByte(9, yr);
  endtask

  // Tick, then check busy and done in the cycles they are due (R2)
  task automatic doUpdate(input logic expUip);
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    check("R2 uip start", {7'd0, updInProg}, {7'd0, expUip});
    check("R2 done early", {7'd0, updDone}, 8'd0);
    repeat (PRE + 1) @(posedge clk);
    @(negedge clk);
    check("R2 done due", {7'd0, updDone}, 8'd1);
    check("R2 uip held", {7'd0, updInProg}, {7'd0, expUip});
    @(negedge clk);
    check("R2 done end", {7'd0, updDone}, 8'd0);
    check("R2 uip end", {7'd0, updInProg}, 8'd0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during and after reset
    check("R1 uip", {7'd0, updInProg}, 8'd0);
    check("R1 done", {7'd0, updDone}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) check("R1 byte", ub(i), 8'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      binMode = VECS[v].bin; hour24 = VECS[v].h24; dstEn = VECS[v].dst;
      writeTime(VECS[v].s, VECS[v].m, VECS[v].h, VECS[v].dw,
                VECS[v].dm, VECS[v].mo, VECS[v].yr);
      doUpdate(1'b1);
      check($sformatf("R3-vec%0d sec", v), ub(0), VECS[v].es);
      check($sformatf("R3-vec%0d min", v), ub(2), VECS[v].em);
      check($sformatf("R5-vec%0d hour", v), ub(4), VECS[v].eh);
      check($sformatf("R7-vec%0d dow", v), ub(6), VECS[v].edw);
      check($sformatf("R7-vec%0d dom", v), ub(7), VECS[v].edm);
      check($sformatf("R7-vec%0d month", v), ub(8), VECS[v].emo);
      check($sformatf("R7-vec%0d year", v), ub(9), VECS[v].eyr);
    end

    // R2 a tick during the window is ignored
    @(negedge clk);
    binMode = 1'b0; hour24 = 1'b1; dstEn = 1'b0;
    writeTime(8'h00, 8'h00, 8'h05, 8'h02, 8'h15, 8'h03, 8'h05);
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    repeat (2) @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    repeat (PRE - 1) @(posedge clk);
    @(negedge clk);
    check("R2 single advance", ub(0), 8'h01);
    check("R2 uip cleared", {7'd0, updInProg}, 8'd0);
    repeat (PRE + 4) @(negedge clk);
    check("R2 no second update", ub(0), 8'h01);
    check("R2 uip stays low", {7'd0, updInProg}, 8'd0);

    // R13 alarm bytes hold
    writeByte(1, 8'h45); writeByte(3, 8'h30); writeByte(5, 8'hC0);
    doUpdate(1'b1);
    check("R13 sec alarm", ub(1), 8'h45);
    check("R13 min alarm", ub(3), 8'h30);
    check("R13 hour alarm", ub(5), 8'hC0);

    // R9 inhibit freezes user copy, internal keeps counting
    writeTime(8'h30, 8'h20, 8'h10, 8'h02, 8'h15, 8'h03, 8'h05);
    @(negedge clk); inhibit = 1'b1;
    doUpdate(1'b0);
    check("R9 frozen sec", ub(0), 8'h30);
    doUpdate(1'b0);
    check("R9 frozen sec 2", ub(0), 8'h30);
    @(negedge clk); inhibit = 1'b0;
    repeat (2) @(negedge clk);
    doUpdate(1'b1);
    check("R9 counted on", ub(0), 8'h33);
    check("R9 min", ub(2), 8'h20);

    // R10 write while inhibited takes effect when released
    @(negedge clk); inhibit = 1'b1;
    writeByte(0, 8'h45);
    check("R10 write visible", ub(0), 8'h45);
    doUpdate(1'b0);
    check("R10 held while inhibited", ub(0), 8'h45);
    @(negedge clk); inhibit = 1'b0;
    repeat (2) @(negedge clk);
    doUpdate(1'b1);
    check("R10 loaded sec", ub(0), 8'h46);
    check("R10 kept min", ub(2), 8'h20);
    check("R10 kept hour", ub(4), 8'h10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule